// File: doc/BRIEF.md
# General-Purpose Pin Controller with Set/Clear Interrupt Control

This block controls sixteen general-purpose pins. Each pin is either an input or an output, chosen by a direction register. Output data and interrupt-enable bits are never rewritten as whole words. Software changes them through paired registers: one sets the bits written as one, the other clears them. This avoids read-modify-write races between software contexts. Inputs pass through a two-flop synchronizer before any logic looks at them.

Every pin can raise an interrupt. The source is the external signal for an input pin and the software-written data bit for an output pin, so an output pin acts as a software interrupt. Per pin, software chooses the active polarity and whether the pin is level or edge sensitive. In edge mode it also chooses between the single edge set by the polarity and both edges. Edge events are held in a status register until software clears them. Level status follows the pin. A single registered interrupt request is the OR of the enabled status bits.

The block sits on a simple word-addressed bus with a write strobe and a registered read path.

Top module: `pin_ctrl_gpio`

## Requirements
- R1: Register 0 holds the direction bits, where 1 means output. The output enable `pin_oe` equals this register one cycle after a write. It resets to 0, so all pins start as inputs.
- R2: A write to register 2 sets the output data bits written as 1, and a write to register 3 clears them. All other bits keep their value. `pin_out` carries the new value one cycle after the write, and reading register 2 or 3 returns it.
- R3: Reading register 1 returns the pin states. Input pins show `pin_in` after two synchronizer stages, and output pins show their output data bit.
- R4: A write to register 4 sets the interrupt-mask bits written as 1, and a write to register 5 clears them. Reading register 4 or 5 returns the mask.
- R5: In register 6, a polarity bit of 1 makes the pin active-low in level mode and falling-edge triggered in single-edge mode. A bit of 0 means active-high or rising edge.
- R6: In register 7, a bit of 1 selects edge mode for the pin. In register 8, a bit of 1 in edge mode makes both edges trigger, regardless of polarity.
- R7: Reading register 9 returns the status bits. An edge event sets its status bit, and the bit stays set until a 1 is written to that bit of register 9. Zeros written there have no effect. An event in the same cycle as a clear wins.
- R8: In level mode the status bit equals the pin's active level, and writes to register 9 do not change it.
- R9: `irq` is a registered OR over all pins of status AND mask. When the mask is all zero, `irq` is low.
- R10: For an output pin, the interrupt source is its output data bit, and `pin_in` for that pin has no effect on status.
- R11: Read data is registered: `bus_rdata` shows the register addressed in the previous cycle. Addresses 10 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | External pin levels |
| pin_out | output | 16 | Output data register |
| pin_oe | output | 16 | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong latch or edge-detector state is visible through register 9 and on `irq`. An input edge reaches the status bit three clock edges after the pin changes, and `irq` one edge later. A missed or spurious event, or a bit that will not clear, therefore shows up within five cycles. A broken set/clear path shows on `pin_out` or on the mask readback one cycle after the write. The collision case, a clear in the same cycle as an event, is aimed at that exact edge so that a lost event shows as a cleared status bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_AW = 4;
  localparam logic [REG_AW-1:0] A_DIR  = 4'd0;
  localparam logic [REG_AW-1:0] A_PINS = 4'd1;
  localparam logic [REG_AW-1:0] A_DSET = 4'd2;
  localparam logic [REG_AW-1:0] A_DCLR = 4'd3;
  localparam logic [REG_AW-1:0] A_MSET = 4'd4;
  localparam logic [REG_AW-1:0] A_MCLR = 4'd5;
  localparam logic [REG_AW-1:0] A_POL  = 4'd6;
  localparam logic [REG_AW-1:0] A_EDGE = 4'd7;
  localparam logic [REG_AW-1:0] A_BOTH = 4'd8;
  localparam logic [REG_AW-1:0] A_STAT = 4'd9;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[s] <= '0;
        else if (s == 0) st[s] <= d;
        else st[s] <= st[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      pin_val,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      edge_q,
  output logic [N-1:0]      both_q,
  output logic [N-1:0]      stat_clr,
  output logic [N-1:0]      rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
    end else if (wr) begin
      case (addr)
        A_DIR:  dir_q  <= wdata;
        A_DSET: out_q  <= out_q | wdata;
        A_DCLR: out_q  <= out_q & ~wdata;
        A_MSET: mask_q <= mask_q | wdata;
        A_MCLR: mask_q <= mask_q & ~wdata;
        A_POL:  pol_q  <= wdata;
        A_EDGE: edge_q <= wdata;
        A_BOTH: both_q <= wdata;
        default: ;
      endcase
    end
  end

  assign stat_clr = (wr && addr == A_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_DIR:          rdata <= dir_q;
        A_PINS:         rdata <= pin_val;
        A_DSET, A_DCLR: rdata <= out_q;
        A_MSET, A_MCLR: rdata <= mask_q;
        A_POL:          rdata <= pol_q;
        A_EDGE:         rdata <= edge_q;
        A_BOTH:         rdata <= both_q;
        A_STAT:         rdata <= status;
        default:        rdata <= '0;
      endcase
    end
  end

  assert_data_set_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_DSET) |=> ((out_q & $past(wdata)) == $past(wdata)));
  assert_data_clr_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_DCLR) |=> ((out_q & $past(wdata)) == '0));
  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_MCLR) |=> ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic pol,
  input  logic edge_mode,
  input  logic both,
  input  logic clr,
  output logic status
);
  logic prev_q, lat_q, evt, act;

  assign act = src ^ pol;
  assign evt = both ? (src ^ prev_q) : (act & ~(prev_q ^ pol));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= src;
      if (!edge_mode) lat_q <= 1'b0;
      else if (evt)   lat_q <= 1'b1;
      else if (clr)   lat_q <= 1'b0;
    end
  end

  assign status = edge_mode ? lat_q : act;

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && lat_q && !clr) |=> lat_q);
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && evt && clr) |=> lat_q);
endmodule

// File: rtl/pin_ctrl_gpio.sv
module pin_ctrl_gpio
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] in_s, src, status, stat_clr;
  logic [NPINS-1:0] dir_q, out_q, mask_q, pol_q, edge_q, both_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(in_s));

  assign src = (dir_q & out_q) | (~dir_q & in_s);

  gpio_regs #(.N(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pin_val(src), .status(status),
    .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q), .pol_q(pol_q),
    .edge_q(edge_q), .both_q(both_q), .stat_clr(stat_clr), .rdata(bus_rdata));

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      gpio_pin_irq u_pin (
        .clk(clk), .rst(rst), .src(src[p]), .pol(pol_q[p]),
        .edge_mode(edge_q[p]), .both(both_q[p]), .clr(stat_clr[p]),
        .status(status[p]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & mask_q);
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  assert_dir_oe_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DIR) |=> (pin_oe == $past(bus_wdata)));
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);
endmodule

// File: tb/pin_ctrl_gpio_bench.sv
module pin_ctrl_gpio_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {addr, write data, expected readback}
  localparam logic [35:0] VEC [NV] = '{
    {4'h2, 16'h00FF, 16'h00FF}, {4'h2, 16'hF000, 16'hF0FF},
    {4'h3, 16'h000F, 16'hF0F0}, {4'h3, 16'h0000, 16'hF0F0},
    {4'h2, 16'h0000, 16'hF0F0}, {4'h3, 16'hFFFF, 16'h0000},
    {4'h2, 16'hA5A5, 16'hA5A5}, {4'h3, 16'h8001, 16'h25A4},
    {4'h4, 16'h0003, 16'h0003}, {4'h4, 16'h0100, 16'h0103},
    {4'h5, 16'h0001, 16'h0102}, {4'h5, 16'hFFFF, 16'h0000}};

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, pin_in = '0;
  logic [15:0] bus_rdata, pin_out, pin_oe;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [15:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_ctrl_gpio u_pin_ctrl_gpio (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state (R1, R2, R9)
    chk("R1 reset pin_oe", pin_oe, 16'h0);
    chk("R2 reset pin_out", pin_out, 16'h0);
    chk("R9 reset irq", {15'h0, irq}, 16'h0);

    // table of set/clear writes (R2 data, R4 mask)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], r);
      if (VEC[i][35:32] >= 4'h4) chk("R4 mask readback", r, VEC[i][15:0]);
      else begin
        chk("R2 data readback", r, VEC[i][15:0]);
        chk("R2 pin_out", pin_out, VEC[i][15:0]);
      end
    end

    // R1 direction
    wr(4'h0, 16'h00F0);
    chk("R1 pin_oe", pin_oe, 16'h00F0);
    // R3 pin readback, mixed directions
    pin_in = 16'h1234; settle();
    rd(4'h1, r); chk("R3 pin readback", r, 16'h12A4);
    pin_in = 16'h0; wr(4'h0, 16'h0); settle();

    // R8 level mode
    wr(4'h4, 16'h0001);
    pin_in[0] = 1'b1; settle();
    chk("R8 level irq", {15'h0, irq}, 16'h1);
    wr(4'h9, 16'h0001);
    rd(4'h9, r); chk("R8 level status ignores clear", r, 16'h0001);
    pin_in[0] = 1'b0; settle();
    rd(4'h9, r); chk("R8 level status follows pin", r, 16'h0);
    chk("R8 level irq low", {15'h0, irq}, 16'h0);
    wr(4'h5, 16'hFFFF);

    // R5 active-low level
    wr(4'h6, 16'h0002); wr(4'h4, 16'h0002); settle();
    rd(4'h9, r); chk("R5 active-low status", r, 16'h0002);
    chk("R5 active-low irq", {15'h0, irq}, 16'h1);
    pin_in[1] = 1'b1; settle();
    rd(4'h9, r); chk("R5 active-low inactive", r, 16'h0);
    wr(4'h5, 16'hFFFF); pin_in[1] = 1'b0; wr(4'h6, 16'h0); settle();

    // R6/R7 rising edge on pin 2
    wr(4'h7, 16'h0004); wr(4'h4, 16'h0004);
    pin_in[2] = 1'b1; settle();
    rd(4'h9, r); chk("R6 rising latched", r, 16'h0004);
    chk("R9 irq on latched", {15'h0, irq}, 16'h1);
    pin_in[2] = 1'b0; settle();
    rd(4'h9, r); chk("R7 held after fall", r, 16'h0004);
    wr(4'h9, 16'h0000);
    rd(4'h9, r); chk("R7 zero write no effect", r, 16'h0004);
    wr(4'h9, 16'h0004); settle();
    rd(4'h9, r); chk("R7 cleared", r, 16'h0);
    chk("R7 irq after clear", {15'h0, irq}, 16'h0);

    // R5 falling edge
    wr(4'h6, 16'h0004);
    pin_in[2] = 1'b1; settle();
    rd(4'h9, r); chk("R5 rise ignored in falling mode", r, 16'h0);
    pin_in[2] = 1'b0; settle();
    rd(4'h9, r); chk("R5 falling latched", r, 16'h0004);
    wr(4'h9, 16'h0004); wr(4'h6, 16'h0);

    // R6 both edges
    wr(4'h8, 16'h0004);
    pin_in[2] = 1'b1; settle();
    rd(4'h9, r); chk("R6 both rise", r, 16'h0004);
    wr(4'h9, 16'h0004);
    rd(4'h9, r); chk("R6 both cleared", r, 16'h0);
    pin_in[2] = 1'b0; settle();
    rd(4'h9, r); chk("R6 both fall", r, 16'h0004);
    wr(4'h9, 16'h0004); settle();

    // R7 event and clear on the same edge
    pin_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(4'h9, 16'h0004);
    rd(4'h9, r); chk("R7 event wins over clear", r, 16'h0004);
    pin_in[2] = 1'b0; settle();
    wr(4'h9, 16'h0004);

    // R10 software interrupt on output pin 3
    wr(4'h8, 16'h0); wr(4'h0, 16'h0008); wr(4'h7, 16'h000C); wr(4'h4, 16'h0008);
    pin_in[3] = 1'b1; settle();
    rd(4'h9, r); chk("R10 pin_in ignored on output", r, 16'h0);
    chk("R10 no irq from pin_in", {15'h0, irq}, 16'h0);
    wr(4'h2, 16'h0008); settle();
    rd(4'h9, r); chk("R10 software event", r, 16'h0008);
    chk("R10 software irq", {15'h0, irq}, 16'h1);

    // R9 all masked
    wr(4'h5, 16'hFFFF); settle();
    chk("R9 masked irq", {15'h0, irq}, 16'h0);
    rd(4'h9, r); chk("R9 status kept while masked", r, 16'h0008);

    // R11 unmapped
    rd(4'hF, r); chk("R11 unmapped reads zero", r, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule